// File: doc/BRIEF.md
# Touch controller serial slave front end

This block is the two-wire serial slave side of a resistive touch-panel controller. It watches raw SCL and SDA on a fast system clock. Both lines pass through a synchronizer and a three-sample majority vote. The block then finds START, repeated START and STOP conditions on the cleaned lines and matches a 7-bit device address. The low bit of that address is set by a board-level select pin. On a write it takes a single command byte and publishes its fields as registered outputs. On a read it raises a conversion request and returns the converter result most significant bit first. The result goes out as a left-justified 12-bit word over two bytes, or as one byte in 8-bit mode.

SDA is driven open-drain: `sda_oe` high means the block pulls the line low. The command written last is kept. A repeated START that carries the read address therefore starts a new conversion and readout with no new write.

Top module: `touch_i2c_slave`

## Requirements
- R1: A pulse on SCL or SDA lasting one system clock is ignored. A command byte sent with such glitches on every bit decodes exactly as one sent without them.
- R2: The device address is binary 100100 followed by the `addr_sel` level. The eighth bit is 0 for write and 1 for read. On a match the block pulls SDA low through the ninth clock of the address byte.
- R3: After an address that does not match, SDA stays released until the next START. No strobe fires and the command fields do not change.
- R4: A write's command byte is taken MSB first and acknowledged in its ninth clock. The fields come from these bits: bit 7 to `cmd_start`, bits 6..4 to `cmd_chan`, bit 2 to `cmd_pd` and bit 1 to `cmd_mode`. Bits 3 and 0 are ignored. `cmd_valid` pulses for one clock when the fields are loaded.
- R5: Exactly one command byte is taken per write. A further byte in the same write gets no acknowledge and leaves the fields unchanged.
- R6: A matching read address makes `rd_start` pulse once. `conv_req` pulses in the same clock, but only if a command has been accepted since reset.
- R7: With `cmd_mode` 0 (12-bit), the first read byte is result bits 11..4. After a master ACK, the second byte is result bits 3..0 followed by four zeros.
- R8: With `cmd_mode` 1 (8-bit), only the first byte (result bits 11..4) is driven. SDA stays released after it even if the master acknowledges.
- R9: A master NACK after the first byte in 12-bit mode releases SDA for the rest of the transaction.
- R10: A repeated START carrying the read address starts a new conversion and readout with the last written command. `cmd_valid` does not fire.
- R11: A STOP at any point ends the transfer and releases SDA. The next START is served normally.
- R12: `sda_oe` changes only while SCL is low.
- R13: While reset is held, `sda_oe`, all strobes and all command fields are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line level |
| addr_sel | input | 1 | Level for the low device address bit |
| result | input | RES_W | Conversion result word from the converter |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| cmd_start | output | 1 | Command bit 7 (start bit) |
| cmd_chan | output | 3 | Command bits 6..4 (channel select) |
| cmd_pd | output | 1 | Command bit 2 (power-down) |
| cmd_mode | output | 1 | Command bit 1: 0 = 12-bit, 1 = 8-bit result |
| cmd_valid | output | 1 | One-clock strobe when a command byte is accepted |
| rd_start | output | 1 | One-clock strobe when a read address is matched |
| conv_req | output | 1 | One-clock conversion request at a read start |

## Verification
The assertions take some things for granted about the bus. SCL stays in each phase far longer than the few clocks of filter latency. SDA moves only well inside an SCL low phase, except for deliberate START and STOP. The master never tries a START or STOP while the slave holds SDA low. Under those conditions SCL is high and steady while `sda_oe` holds still, and a STOP is always followed by a released line. The stimulus keeps to this. Each SCL phase lasts 24 clocks, and SDA is moved 12 clocks after SCL falls. Glitches are single-clock pulses placed clear of the real edges. A STOP is issued only after bits in which the slave has released SDA.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam logic [5:0] DEV_ADDR_HI = 6'b100100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_CMD,
    ST_CACK,
    ST_TX,
    ST_MACK,
    ST_WAIT
  } tsi_state_e;
endpackage

// File: rtl/tsi_line_filter.sv
module tsi_line_filter #(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] clean
);
  genvar g;
  generate
    for (g = 0; g < LINES; g++) begin : g_line
      logic [SYNC_STAGES-1:0] sync_q;
      logic [2:0]             win_q;
      logic                   vote_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sync_q <= '1;
          win_q  <= '1;
          vote_q <= 1'b1;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], raw[g]};
          win_q  <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
          vote_q <= (win_q[0] & win_q[1]) | (win_q[1] & win_q[2]) | (win_q[0] & win_q[2]);
        end
      end
      assign clean[g] = vote_q;
    end
  endgenerate
endmodule

// File: rtl/tsi_bus_events.sv
module tsi_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_ev = scl_q & scl_f & sda_q & ~sda_f;
  assign stop_ev  = scl_q & scl_f & ~sda_q & sda_f;
  assign scl_rise = ~scl_q & scl_f;
  assign scl_fall = scl_q & ~scl_f;
endmodule

// File: rtl/tsi_engine.sv
module tsi_engine
  import tsi_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_f,
  input  logic             addr_sel,
  input  logic [RES_W-1:0] result,
  output logic             sda_oe,
  output logic             cmd_start,
  output logic [2:0]       cmd_chan,
  output logic             cmd_pd,
  output logic             cmd_mode,
  output logic             cmd_valid,
  output logic             rd_start,
  output logic             conv_req
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BITS = CNT_W'(8);
  localparam int LOW_W = RES_W - 8;
  localparam int PAD_W = 8 - LOW_W;

  tsi_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shreg;
  logic [6:0]       txsh;
  logic [7:0]       low_byte;
  logic             is_read;
  logic             cmd_seen;
  logic             m_ack;
  logic             more;
  logic             addr_hit;
  logic [7:0]       first_b;
  logic [7:0]       second_b;

  assign addr_hit = (shreg[7:1] == {DEV_ADDR_HI, addr_sel});
  assign first_b  = result[RES_W-1 -: 8];
  assign second_b = {result[LOW_W-1:0], {PAD_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      shreg     <= '0;
      txsh      <= '0;
      low_byte  <= '0;
      is_read   <= 1'b0;
      cmd_seen  <= 1'b0;
      m_ack     <= 1'b0;
      more      <= 1'b0;
      sda_oe    <= 1'b0;
      cmd_start <= 1'b0;
      cmd_chan  <= '0;
      cmd_pd    <= 1'b0;
      cmd_mode  <= 1'b0;
      cmd_valid <= 1'b0;
      rd_start  <= 1'b0;
      conv_req  <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      rd_start  <= 1'b0;
      conv_req  <= 1'b0;
      if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_ev) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_CMD: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_f};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == BITS) begin
              if (st == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe  <= 1'b1;
                  is_read <= shreg[0];
                  st      <= ST_AACK;
                  if (shreg[0]) begin
                    rd_start <= 1'b1;
                    conv_req <= cmd_seen;
                  end
                end else begin
                  st <= ST_WAIT;
                end
              end else begin
                cmd_start <= shreg[7];
                cmd_chan  <= shreg[6:4];
                cmd_pd    <= shreg[2];
                cmd_mode  <= shreg[1];
                cmd_valid <= 1'b1;
                cmd_seen  <= 1'b1;
                sda_oe    <= 1'b1;
                st        <= ST_CACK;
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (is_read) begin
                txsh     <= first_b[6:0];
                low_byte <= second_b;
                sda_oe   <= ~first_b[7];
                more     <= ~cmd_mode;
                st       <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_CMD;
              end
            end
          end
          ST_CACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_WAIT;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == BITS) begin
                sda_oe <= 1'b0;
                st     <= ST_MACK;
              end else begin
                sda_oe <= ~txsh[6];
                txsh   <= {txsh[5:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_f;
            end else if (scl_fall) begin
              if (m_ack && more) begin
                txsh   <= low_byte[6:0];
                sda_oe <= ~low_byte[7];
                more   <= 1'b0;
                cnt    <= '0;
                st     <= ST_TX;
              end else begin
                st <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/touch_i2c_slave.sv
module touch_i2c_slave #(
  parameter int RES_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             addr_sel,
  input  logic [RES_W-1:0] result,
  output logic             sda_oe,
  output logic             cmd_start,
  output logic [2:0]       cmd_chan,
  output logic             cmd_pd,
  output logic             cmd_mode,
  output logic             cmd_valid,
  output logic             rd_start,
  output logic             conv_req
);
  logic [1:0] clean;
  logic       scl_f, sda_f;
  logic       bus_start, bus_stop, scl_rise, scl_fall;

  tsi_line_filter #(.LINES(2), .SYNC_STAGES(SYNC_STAGES)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .raw   ({scl_i, sda_i}),
    .clean (clean)
  );

  assign scl_f = clean[1];
  assign sda_f = clean[0];

  tsi_bus_events u_ev (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .start_ev (bus_start),
    .stop_ev  (bus_stop),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  tsi_engine #(.RES_W(RES_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start_ev  (bus_start),
    .stop_ev   (bus_stop),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .sda_f     (sda_f),
    .addr_sel  (addr_sel),
    .result    (result),
    .sda_oe    (sda_oe),
    .cmd_start (cmd_start),
    .cmd_chan  (cmd_chan),
    .cmd_pd    (cmd_pd),
    .cmd_mode  (cmd_mode),
    .cmd_valid (cmd_valid),
    .rd_start  (rd_start),
    .conv_req  (conv_req)
  );
endmodule

// File: rtl/tsi_checker.sv
module tsi_checker (
  input logic       clk,
  input logic       rst,
  input logic       scl_f,
  input logic       stop_ev,
  input logic       sda_oe,
  input logic       cmd_start,
  input logic [2:0] cmd_chan,
  input logic       cmd_pd,
  input logic       cmd_mode,
  input logic       cmd_valid,
  input logic       rd_start,
  input logic       conv_req
);
  assert_sda_still_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(scl_f) && scl_f) |-> $stable(sda_oe));

  assert_cmd_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  assert_fields_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable({cmd_start, cmd_chan, cmd_pd, cmd_mode}) |-> cmd_valid);

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rd_start |=> !rd_start);

  assert_conv_with_read_R6: assert property (@(posedge clk) disable iff (rst)
    conv_req |-> rd_start);

  assert_stop_release_R11: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_oe);
endmodule

bind touch_i2c_slave tsi_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_f     (scl_f),
  .stop_ev   (bus_stop),
  .sda_oe    (sda_oe),
  .cmd_start (cmd_start),
  .cmd_chan  (cmd_chan),
  .cmd_pd    (cmd_pd),
  .cmd_mode  (cmd_mode),
  .cmd_valid (cmd_valid),
  .rd_start  (rd_start),
  .conv_req  (conv_req)
);

// File: tb/sim_touch_i2c_slave.sv
`timescale 1ns/1ps
module sim_touch_i2c_slave;
  localparam int L = 24;
  localparam int H = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_i = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_gl = 1'b0;
  logic        sda_i;
  logic        addr_sel = 1'b0;
  logic [11:0] result = '0;
  logic        sda_oe, cmd_start, cmd_pd, cmd_mode, cmd_valid, rd_start, conv_req;
  logic [2:0]  cmd_chan;

  int checks = 0, errors = 0;
  int n_cmd = 0, n_rd = 0, n_conv = 0;
  int e_cmd = 0, e_rd = 0, e_conv = 0;
  int r12_bad = 0, high_cnt = 0;
  logic prev_oe = 1'b0;
  bit glitch = 1'b0;
  bit done = 1'b0;
  logic [7:0] last_cmd = 8'h00;

  always #2 clk = ~clk;

  assign sda_i = sda_m & ~sda_gl & ~sda_oe;

  touch_i2c_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .addr_sel(addr_sel),
    .result(result), .sda_oe(sda_oe), .cmd_start(cmd_start), .cmd_chan(cmd_chan),
    .cmd_pd(cmd_pd), .cmd_mode(cmd_mode), .cmd_valid(cmd_valid),
    .rd_start(rd_start), .conv_req(conv_req)
  );

  // per-clock model: strobe tallies and R12 (no SDA drive change with SCL settled high)
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_valid) n_cmd++;
      if (rd_start) n_rd++;
      if (conv_req) n_conv++;
      if (high_cnt > 8 && sda_oe != prev_oe) r12_bad++;
    end
    high_cnt = scl_i ? high_cnt + 1 : 0;
    prev_oe = sda_oe;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b, output logic got);
    if (glitch) begin
      tick(4); scl_i = 1'b1; tick(1); scl_i = 1'b0; tick(L/2 - 5);
    end else tick(L/2);
    sda_m = b;
    tick(L/2);
    scl_i = 1'b1;
    if (glitch) begin
      tick(3); sda_gl = 1'b1; tick(1); sda_gl = 1'b0; tick(H/2 - 4);
    end else tick(H/2);
    got = sda_i;
    tick(H/2);
    scl_i = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b0; tick(H/2); scl_i = 1'b0;
  endtask

  task automatic bus_rstart();
    tick(L/2); sda_m = 1'b1; tick(L/2); scl_i = 1'b1;
    tick(H/2); sda_m = 1'b0; tick(H/2); scl_i = 1'b0;
  endtask

  task automatic bus_stop();
    tick(L/2); sda_m = 1'b0; tick(L/2); scl_i = 1'b1;
    tick(H/2); sda_m = 1'b1; tick(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) send_bit(b[i], g);
    send_bit(1'b1, g);
    ack = ~g;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, g);
      d[i] = g;
    end
    send_bit(~mack, g);
  endtask

  task automatic chk_fields(input string req, input logic [7:0] b);
    chk(req, {cmd_start, cmd_chan, cmd_pd, cmd_mode}, {b[7], b[6:4], b[2], b[1]});
  endtask

  task automatic chk_counts(input string req);
    chk(req, n_cmd, e_cmd);
    chk(req, n_rd, e_rd);
    chk(req, n_conv, e_conv);
  endtask

  function automatic logic [7:0] hi_byte(input logic [11:0] r);
    return r[11:4];
  endfunction

  function automatic logic [7:0] lo_byte(input logic [11:0] r);
    return {r[3:0], 4'h0};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", 150000);
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] d;
    tick(6);
    // R13: reset state
    chk("R13", {sda_oe, cmd_valid, rd_start, conv_req}, 0);
    chk("R13", {cmd_start, cmd_chan, cmd_pd, cmd_mode}, 0);
    rst = 1'b0;
    tick(10);

    // read before any command: 12-bit default, no conversion request (R6, R7, R2)
    addr_sel = 1'b0; result = 12'hA5C;
    bus_start(); wr_byte(8'h91, a); chk("R2", a, 1);
    e_rd++;
    rd_byte(1'b1, d); chk("R7", d, hi_byte(12'hA5C));
    rd_byte(1'b0, d); chk("R7", d, lo_byte(12'hA5C));
    bus_stop(); chk_counts("R6");

    // mismatching address (R3)
    bus_start(); wr_byte(8'h92, a); chk("R3", a, 0);
    wr_byte(8'hD6, a); chk("R3", a, 0);
    bus_stop(); chk_fields("R3", 8'h00); chk_counts("R3");

    // write command with don't-care bits set (R2, R4, R5)
    addr_sel = 1'b1;
    bus_start(); wr_byte(8'h92, a); chk("R2", a, 1);
    wr_byte(8'h39, a); chk("R4", a, 1);
    e_cmd++; last_cmd = 8'h39;
    chk_fields("R4", 8'h39);
    wr_byte(8'hFF, a); chk("R5", a, 0);
    chk_fields("R5", 8'h39);
    bus_stop(); chk_counts("R5");

    // 12-bit read after a command (R6, R7)
    result = 12'h3E7;
    bus_start(); wr_byte(8'h93, a); chk("R2", a, 1);
    e_rd++; e_conv++;
    rd_byte(1'b1, d); chk("R7", d, hi_byte(12'h3E7));
    rd_byte(1'b0, d); chk("R7", d, lo_byte(12'h3E7));
    bus_stop(); chk_counts("R6");

    // NACK after first byte releases the line (R9)
    result = 12'h5A5;
    bus_start(); wr_byte(8'h93, a);
    e_rd++; e_conv++;
    rd_byte(1'b0, d); chk("R9", d, hi_byte(12'h5A5));
    rd_byte(1'b0, d); chk("R9", d, 8'hFF);
    bus_stop(); chk_counts("R9");

    // 8-bit mode, then repeated START reads (R4, R8, R10)
    bus_start(); wr_byte(8'h92, a); wr_byte(8'hD6, a); chk("R4", a, 1);
    e_cmd++; last_cmd = 8'hD6;
    chk_fields("R4", 8'hD6);
    result = 12'h0C3;
    bus_rstart(); wr_byte(8'h93, a); chk("R10", a, 1);
    e_rd++; e_conv++;
    rd_byte(1'b1, d); chk("R8", d, hi_byte(12'h0C3));
    rd_byte(1'b0, d); chk("R8", d, 8'hFF);
    result = 12'hFA0;
    bus_rstart(); wr_byte(8'h93, a); chk("R10", a, 1);
    e_rd++; e_conv++;
    rd_byte(1'b0, d); chk("R10", d, hi_byte(12'hFA0));
    bus_stop(); chk_counts("R10"); chk_fields("R10", 8'hD6);

    // glitches on every bit of a command (R1)
    bus_start(); wr_byte(8'h92, a);
    glitch = 1'b1; wr_byte(8'h39, a); glitch = 1'b0;
    chk("R1", a, 1);
    e_cmd++; last_cmd = 8'h39;
    bus_stop(); chk_fields("R1", 8'h39); chk_counts("R1");

    // STOP in the middle of a command byte (R11)
    bus_start(); wr_byte(8'h92, a);
    for (int i = 0; i < 4; i++) send_bit(1'b1, a);
    bus_stop();
    chk("R11", sda_oe, 0); chk_fields("R11", 8'h39); chk_counts("R11");
    result = 12'h801;
    bus_start(); wr_byte(8'h93, a); chk("R11", a, 1);
    e_rd++; e_conv++;
    rd_byte(1'b1, d); chk("R11", d, hi_byte(12'h801));
    rd_byte(1'b0, d); chk("R11", d, lo_byte(12'h801));
    bus_stop(); chk_counts("R11"); chk("R11", sda_oe, 0);

    chk("R12", r12_bad, 0);
    finish_run();
  end
endmodule